// File: doc/BRIEF.md
# RTC Alarm and Periodic Interrupt Unit

This unit sits beside a real-time-clock timekeeping core. It watches the live calendar time, which arrives as six BCD fields, together with four rollover strobes that pulse once per second, minute, hour and day. Software programs an alarm instant and an interrupt control byte through a simple byte-wide register port. The unit raises sticky event flags and drives one level interrupt line toward the host.

Each rollover strobe sets its own sticky flag. An alarm flag is set on the second tick when all six live fields equal the programmed alarm fields. A power-up flag marks that the unit came out of reset. Every flag is cleared only by writing a one to its bit. The interrupt line combines two sources: the alarm flag, when the alarm is enabled, and one periodic flag picked by a two-bit period select, when the timer is enabled. Masking acts on the line only, so flags still collect while their interrupt is disabled.

Top module: `rtc_alarm_irq_unit`

## Requirements
- R1: After the synchronous active-low reset, all six alarm registers read 0x00, the control register reads 0x00, the status register reads 0x80 and `irq` is low.
- R2: The alarm fields sit at register addresses 0x07 (seconds), 0x08 (minutes), 0x09 (hours), 0x0A (day), 0x0B (month) and 0x0C (year), each 8-bit BCD and readable back. The control register at 0x0F keeps bits [3:0]. Bits [7:4] read 0, and unmapped addresses read 0x00.
- R3: Status bit 6 (alarm) is set one cycle after a cycle in which `tick_sec` is high and all six live fields equal the stored alarm fields. It is not set when `tick_sec` is low or when any field differs.
- R4: Status bits 2, 3, 4 and 5 are set one cycle after `tick_sec`, `tick_min`, `tick_hour` and `tick_day` respectively. This happens whatever the interrupt enables are.
- R5: A write to the status address 0x0E clears each status bit whose data bit is 1 and leaves the other bits alone. A write to any other address never changes status.
- R6: When a flag is set and written with 1 for clearing in the same cycle, the flag ends up set.
- R7: Status bit 7 (power-up) is set only by reset and stays set until it is cleared by a write of 1.
- R8: `irq` equals (status bit 6 AND control bit 3) OR (status bit (2 + control[1:0]) AND control bit 2). Control[1:0] selects 0 = second, 1 = minute, 2 = hour, 3 = day.
- R9: With the alarm enabled, `irq` stays high from the setting of the alarm flag until that flag is cleared. Further ticks do not drop it.
- R10: Status bits 1 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (cold start) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| cur_sec | input | 8 | Live seconds, BCD |
| cur_min | input | 8 | Live minutes, BCD |
| cur_hour | input | 8 | Live hours, BCD |
| cur_day | input | 8 | Live day of month, BCD |
| cur_mon | input | 8 | Live month, BCD |
| cur_year | input | 8 | Live year, BCD |
| tick_sec | input | 1 | One-cycle strobe at each second rollover |
| tick_min | input | 1 | One-cycle strobe at each minute rollover |
| tick_hour | input | 1 | One-cycle strobe at each hour rollover |
| tick_day | input | 1 | One-cycle strobe at each day rollover |
| irq | output | 1 | Level interrupt request |

## Verification
Flag setting and the write-one clear can land in the same clock. A rollover strobe or an alarm hit can meet a status write that targets the same bit. The bench drives such a strobe in exactly the cycle of the clearing write. It expects the flag to stay set while the neighbouring bits in the same write are cleared. A second collision is an alarm register write in the same cycle as a matching second tick; there the comparison must use the value stored before the write.

// File: rtl/rtc_alarm_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the RTC alarm/periodic interrupt unit.
// Assumes an 8-bit register file. The bit positions below are decoded by
// host software, so they are fixed.
package rtc_alarm_pkg;

    // Status register bit positions
    localparam int STAT_TICK_LSB = 2;   // bits 2..5: sec, min, hour, day
    localparam int STAT_ALARM    = 6;
    localparam int STAT_PWRUP    = 7;
    localparam int NUM_TICKS     = 4;

    // Control register bit positions
    localparam int CTL_TMR_EN    = 2;
    localparam int CTL_ALM_EN    = 3;
    localparam int CTL_W         = 4;

    // Values of the period select field
    typedef enum logic [1:0] {
        PER_SECOND = 2'd0,
        PER_MINUTE = 2'd1,
        PER_HOUR   = 2'd2,
        PER_DAY    = 2'd3
    } period_sel_e;

endpackage

// File: rtl/rtc_alarm_regs.sv
`timescale 1ns/1ps
// Module: rtc_alarm_regs
// Holds the alarm time fields and the interrupt control register.
// Assumes: a write lands on one address per cycle. Each field has its own
// address at ALARM_BASE + index. Reset zeroes everything.
module rtc_alarm_regs #(
    parameter int DW         = 8,
    parameter int AW         = 5,
    parameter int NFIELD     = 6,
    parameter int ALARM_BASE = 7,
    parameter int CTRL_ADDR  = 15,
    parameter int CTL_W      = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    output logic [NFIELD*DW-1:0] alarm_flat,
    output logic [CTL_W-1:0]     ctl_q
);

    localparam logic [AW-1:0] CTRL_A = AW'(CTRL_ADDR);

    generate
        for (genvar f = 0; f < NFIELD; f++) begin : g_field
            localparam logic [AW-1:0] FIELD_A = AW'(ALARM_BASE + f);
            logic [DW-1:0] field_q;

            // Alarm field storage, loaded by a write to its own address
            always_ff @(posedge clk) begin
                if (!rst_n)
                    field_q <= '0;
                else if (wr_en && (wr_addr == FIELD_A))
                    field_q <= wr_data;
            end

            assign alarm_flat[f*DW +: DW] = field_q;
        end
    endgenerate

    // Control register: period select and the two interrupt enables
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (wr_en && (wr_addr == CTRL_A))
            ctl_q <= wr_data[CTL_W-1:0];
    end

endmodule

// File: rtl/rtc_alarm_match.sv
`timescale 1ns/1ps
// Module: rtc_alarm_match
// Compares each live time field with the stored alarm field. It reports a
// hit in the cycle of a second tick when all fields are equal.
// Assumes: the live fields are stable in the cycle of the tick.
module rtc_alarm_match #(
    parameter int DW     = 8,
    parameter int NFIELD = 6
) (
    input  logic [NFIELD*DW-1:0] live_flat,
    input  logic [NFIELD*DW-1:0] alarm_flat,
    input  logic                 tick_sec,
    output logic                 hit
);

    logic [NFIELD-1:0] field_eq;

    generate
        for (genvar f = 0; f < NFIELD; f++) begin : g_cmp
            // Per-field equality
            assign field_eq[f] = (live_flat[f*DW +: DW] == alarm_flat[f*DW +: DW]);
        end
    endgenerate

    // A hit needs all fields equal and a second tick
    assign hit = tick_sec && (&field_eq);

endmodule

// File: rtl/rtc_event_status.sv
`timescale 1ns/1ps
// Module: rtc_event_status
// Sticky status flags: four periodic tick flags, the alarm flag and the
// power-up flag. Each flag is cleared by writing 1 to its bit. A set in the
// same cycle wins over the clear.
// Assumes: the tick strobes last one cycle. Reset is the cold start.
module rtc_event_status #(
    parameter int DW        = 8,
    parameter int AW        = 5,
    parameter int STAT_ADDR = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [rtc_alarm_pkg::NUM_TICKS-1:0] ticks,
    input  logic          alarm_hit,
    output logic [DW-1:0] status_q
);

    import rtc_alarm_pkg::*;

    localparam logic [AW-1:0] STAT_A     = AW'(STAT_ADDR);
    localparam logic [DW-1:0] PWRUP_MASK = DW'(1) << STAT_PWRUP;
    localparam logic [DW-1:0] VALID_MASK = ~((DW'(1) << STAT_TICK_LSB) - DW'(1));

    logic [DW-1:0] set_v;
    logic [DW-1:0] clr_v;

    // Collect the set requests from the events of this cycle
    always_comb begin
        set_v = '0;
        for (int k = 0; k < NUM_TICKS; k++)
            set_v[STAT_TICK_LSB + k] = ticks[k];
        set_v[STAT_ALARM] = alarm_hit;
    end

    // Clear mask from a write to the status address
    assign clr_v = (wr_en && (wr_addr == STAT_A)) ? wr_data : '0;

    // Flag update: clear first, then set, with unused low bits held at 0
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= PWRUP_MASK;
        else
            status_q <= ((status_q & ~clr_v) | set_v) & VALID_MASK;
    end

endmodule

// File: rtl/rtc_irq_gen.sv
`timescale 1ns/1ps
// Module: rtc_irq_gen
// Builds the single interrupt line from the status flags and the control
// register. The line is combinational from registered state.
// Assumes: status and control come from registers.
module rtc_irq_gen #(
    parameter int DW    = 8,
    parameter int CTL_W = 4
) (
    input  logic [DW-1:0]    status_q,
    input  logic [CTL_W-1:0] ctl_q,
    output logic             irq
);

    import rtc_alarm_pkg::*;

    logic [NUM_TICKS-1:0] tick_flags;
    period_sel_e          sel;
    logic                 tick_src;
    logic                 alarm_src;

    assign tick_flags = status_q[STAT_TICK_LSB +: NUM_TICKS];
    assign sel        = period_sel_e'(ctl_q[1:0]);

    // Pick the periodic flag named by the period select
    always_comb begin
        unique case (sel)
            PER_SECOND: tick_src = tick_flags[0];
            PER_MINUTE: tick_src = tick_flags[1];
            PER_HOUR:   tick_src = tick_flags[2];
            PER_DAY:    tick_src = tick_flags[3];
            default:    tick_src = 1'b0;
        endcase
    end

    assign alarm_src = status_q[STAT_ALARM] & ctl_q[CTL_ALM_EN];

    // Gate each source by its enable and merge them
    assign irq = alarm_src | (tick_src & ctl_q[CTL_TMR_EN]);

endmodule

// File: rtl/rtc_alarm_irq_unit.sv
`timescale 1ns/1ps
// Module: rtc_alarm_irq_unit (top)
// RTC alarm compare, periodic event flags and interrupt output. The
// timekeeping core supplies the live BCD fields and the rollover strobes.
// Assumes: one write per cycle. Reads are combinational from the registers.
module rtc_alarm_irq_unit #(
    parameter int DW         = 8,
    parameter int AW         = 5,
    parameter int ALARM_BASE = 7,
    parameter int STAT_ADDR  = 14,
    parameter int CTRL_ADDR  = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic [DW-1:0] cur_sec,
    input  logic [DW-1:0] cur_min,
    input  logic [DW-1:0] cur_hour,
    input  logic [DW-1:0] cur_day,
    input  logic [DW-1:0] cur_mon,
    input  logic [DW-1:0] cur_year,
    input  logic          tick_sec,
    input  logic          tick_min,
    input  logic          tick_hour,
    input  logic          tick_day,
    output logic          irq
);

    import rtc_alarm_pkg::*;

    localparam int NFIELD = 6;
    localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);
    localparam logic [AW-1:0] CTRL_A = AW'(CTRL_ADDR);

    logic [NFIELD*DW-1:0]  live_flat;
    logic [NFIELD*DW-1:0]  alarm_flat;
    logic [CTL_W-1:0]      ctl_q;
    logic [DW-1:0]         status_q;
    logic [NUM_TICKS-1:0]  ticks;
    logic                  alarm_hit;

    // Field 0 is seconds, and so on up to field 5, the year
    assign live_flat = {cur_year, cur_mon, cur_day, cur_hour, cur_min, cur_sec};
    assign ticks     = {tick_day, tick_hour, tick_min, tick_sec};

    rtc_alarm_regs #(
        .DW(DW), .AW(AW), .NFIELD(NFIELD),
        .ALARM_BASE(ALARM_BASE), .CTRL_ADDR(CTRL_ADDR), .CTL_W(CTL_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .alarm_flat(alarm_flat), .ctl_q(ctl_q)
    );

    rtc_alarm_match #(.DW(DW), .NFIELD(NFIELD)) u_match (
        .live_flat(live_flat), .alarm_flat(alarm_flat),
        .tick_sec(tick_sec), .hit(alarm_hit)
    );

    rtc_event_status #(.DW(DW), .AW(AW), .STAT_ADDR(STAT_ADDR)) u_status (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ticks(ticks), .alarm_hit(alarm_hit),
        .status_q(status_q)
    );

    rtc_irq_gen #(.DW(DW), .CTL_W(CTL_W)) u_irq (
        .status_q(status_q), .ctl_q(ctl_q), .irq(irq)
    );

    // Read multiplexer over status, control and alarm fields
    always_comb begin
        rd_data = '0;
        if (rd_addr == STAT_A)
            rd_data = status_q;
        else if (rd_addr == CTRL_A)
            rd_data = DW'(ctl_q);
        else
            for (int f = 0; f < NFIELD; f++)
                if (rd_addr == AW'(ALARM_BASE + f))
                    rd_data = alarm_flat[f*DW +: DW];
    end

endmodule

// File: rtl/rtc_alarm_irq_chk.sv
`timescale 1ns/1ps
// Module: rtc_alarm_irq_chk
// Property checker bound into rtc_alarm_irq_unit. It watches the status
// flags, the control register and the interrupt line.
module rtc_alarm_irq_chk #(
    parameter int DW = 8,
    parameter int AW = 5,
    parameter int STAT_ADDR = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          tick_sec,
    input logic          tick_min,
    input logic [DW-1:0] status_q,
    input logic [3:0]    ctl_q,
    input logic          irq
);

    logic stat_wr;
    assign stat_wr = wr_en && (wr_addr == AW'(STAT_ADDR));

    // R4
    sec_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_sec |=> status_q[2]);

    // R6
    min_set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_min && stat_wr && wr_data[3]) |=> status_q[3]);

    // R3
    alarm_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[6]) |-> $past(tick_sec));

    // R7
    pwrup_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status_q[7] |=> !status_q[7]);

    // R5
    pwrup_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[7] && !(stat_wr && wr_data[7])) |=> status_q[7]);

    // R9
    alarm_irq_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[6] && ctl_q[3]) |-> irq);

    // R10
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[1:0] == 2'b00);

endmodule

bind rtc_alarm_irq_unit rtc_alarm_irq_chk #(.DW(DW), .AW(AW), .STAT_ADDR(STAT_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick_sec(tick_sec), .tick_min(tick_min),
    .status_q(status_q), .ctl_q(ctl_q), .irq(irq)
);

// File: tb/rtc_alarm_irq_unit_tb.sv
`timescale 1ns/1ps
module rtc_alarm_irq_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [4:0] rd_addr = 5'h0E;
    logic [7:0] rd_data;
    logic [7:0] t_sec = '0, t_min = '0, t_hour = '0, t_day = '0, t_mon = '0, t_year = '0;
    logic       tk_sec = 0, tk_min = 0, tk_hour = 0, tk_day = 0;
    logic       irq;

    int n_checks = 0;
    int n_fails  = 0;

    // Behavioural reference state
    logic [7:0] m_alm [6];
    logic [3:0] m_ctl;
    logic [7:0] m_stat;

    always #2 clk = ~clk;   // 250 MHz

    rtc_alarm_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cur_sec(t_sec), .cur_min(t_min), .cur_hour(t_hour),
        .cur_day(t_day), .cur_mon(t_mon), .cur_year(t_year),
        .tick_sec(tk_sec), .tick_min(tk_min), .tick_hour(tk_hour),
        .tick_day(tk_day), .irq(irq)
    );

    function automatic logic [7:0] exp_rd(input logic [4:0] a);
        if (a == 5'h0E) return m_stat;
        if (a == 5'h0F) return {4'h0, m_ctl};
        if (a >= 5'h07 && a <= 5'h0C) return m_alm[a - 5'h07];
        return 8'h00;
    endfunction

    function automatic logic exp_irq();
        return (m_stat[6] & m_ctl[3]) | (m_stat[2 + m_ctl[1:0]] & m_ctl[2]);
    endfunction

    task automatic check8(input logic [7:0] got, input logic [7:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // One clock: update the model at the edge, compare at the falling edge
    task automatic step(input string tag);
        logic hit;
        logic [7:0] setv, clrv;
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < 6; i++) m_alm[i] = 8'h00;
            m_ctl  = 4'h0;
            m_stat = 8'h80;
        end else begin
            hit = tk_sec && t_sec == m_alm[0] && t_min == m_alm[1] && t_hour == m_alm[2]
                  && t_day == m_alm[3] && t_mon == m_alm[4] && t_year == m_alm[5];
            setv = {1'b0, hit, tk_day, tk_hour, tk_min, tk_sec, 2'b00};
            clrv = (wr_en && wr_addr == 5'h0E) ? wr_data : 8'h00;
            m_stat = ((m_stat & ~clrv) | setv) & 8'hFC;
            if (wr_en && wr_addr == 5'h0F) m_ctl = wr_data[3:0];
            if (wr_en && wr_addr >= 5'h07 && wr_addr <= 5'h0C) m_alm[wr_addr - 5'h07] = wr_data;
        end
        @(negedge clk);
        check8(rd_data, exp_rd(rd_addr), {tag, " rd_data"});
        check8({7'b0, irq}, {7'b0, exp_irq()}, {tag, " irq"});
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d, input string tag);
        wr_en = 1; wr_addr = a; wr_data = d;
        step(tag);
        wr_en = 0; wr_data = '0;
    endtask

    task automatic set_time(input logic [7:0] s, mi, h, d, mo, y);
        t_sec = s; t_min = mi; t_hour = h; t_day = d; t_mon = mo; t_year = y;
    endtask

    initial begin
        #(4 * 100000);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        step("R1 reset");
        step("R1 reset");
        rst_n = 1;
        rd_addr = 5'h0E; step("R1");
        check8(rd_data, 8'h80, "R1 status after reset");
        check8({7'b0, irq}, 8'h00, "R1 irq after reset");
        rd_addr = 5'h0F; step("R1");
        check8(rd_data, 8'h00, "R1 ctrl after reset");

        // R2 alarm field write/readback
        wr(5'h07, 8'h30, "R2"); wr(5'h08, 8'h59, "R2"); wr(5'h09, 8'h23, "R2");
        wr(5'h0A, 8'h31, "R2"); wr(5'h0B, 8'h12, "R2"); wr(5'h0C, 8'h99, "R2");
        for (int i = 0; i < 6; i++) begin
            rd_addr = 5'(7 + i); step("R2 readback");
        end
        rd_addr = 5'h0B; step("R2");
        check8(rd_data, 8'h12, "R2 month field");
        wr(5'h0F, 8'hFF, "R2"); rd_addr = 5'h0F; step("R2");
        check8(rd_data, 8'h0F, "R2 ctrl upper bits");
        wr(5'h0F, 8'h00, "R2");
        rd_addr = 5'h15; step("R2 unmapped");
        check8(rd_data, 8'h00, "R2 unmapped read");

        // R4 / R3: ticks with mismatched time, enables off
        rd_addr = 5'h0E;
        set_time(8'h30, 8'h59, 8'h23, 8'h31, 8'h12, 8'h98);
        tk_sec = 1; step("R4 sec tick"); tk_sec = 0;
        check8(rd_data, 8'h84, "R4 sec flag, R3 no alarm on year mismatch");
        tk_min = 1; tk_hour = 1; step("R4"); tk_min = 0; tk_hour = 0;
        tk_day = 1; step("R4"); tk_day = 0;
        check8(rd_data, 8'hBC, "R4 all tick flags");
        check8({7'b0, irq}, 8'h00, "R8 masked");

        // R5 partial clear and writes elsewhere
        wr(5'h0E, 8'h14, "R5"); step("R5");
        check8(rd_data, 8'hA8, "R5 partial clear");
        wr(5'h10, 8'hFF, "R5 other addr"); step("R5");
        check8(rd_data, 8'hA8, "R5 other address untouched");
        wr(5'h0E, 8'h3C, "R5");

        // R8 period select with timer enabled
        for (int s = 0; s < 4; s++) begin
            wr(5'h0F, 8'(4 + s), "R8 select");
            tk_sec = (s == 0); tk_min = (s == 1); tk_hour = (s == 2); tk_day = (s == 3);
            step("R8"); tk_sec = 0; tk_min = 0; tk_hour = 0; tk_day = 0;
            check8({7'b0, irq}, 8'h01, "R8 selected tick irq");
            wr(5'h0E, 8'h3C, "R8 clear"); step("R8");
            check8({7'b0, irq}, 8'h00, "R8 irq drops after clear");
        end
        tk_hour = 1; wr(5'h0F, 8'h05, "R8 wrong period"); tk_hour = 0;
        step("R8"); check8({7'b0, irq}, 8'h00, "R8 other period ignored");
        wr(5'h0E, 8'h3C, "R8");

        // R3 no match without tick
        set_time(8'h30, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99);
        step("R3 no tick"); check8(rd_data, 8'h80, "R3 no alarm without tick");

        // R3 / R9 alarm match and hold
        wr(5'h0F, 8'h08, "R9 alarm enable");
        tk_sec = 1; step("R3 match"); tk_sec = 0;
        check8(rd_data, 8'hC4, "R3 alarm flag set");
        for (int i = 0; i < 5; i++) begin
            tk_sec = 1; step("R9 hold"); tk_sec = 0;
            check8({7'b0, irq}, 8'h01, "R9 alarm irq held");
        end
        wr(5'h0E, 8'h40, "R9 clear alarm"); step("R9");
        check8({7'b0, irq}, 8'h00, "R9 irq released");

        // R6 set-and-clear collision; alarm write in tick cycle uses old value
        tk_min = 1; wr(5'h0E, 8'h0C, "R6 collision"); tk_min = 0;
        step("R6"); check8(rd_data, 8'h88, "R6 set wins, sec cleared");
        tk_sec = 1; wr(5'h0C, 8'h01, "R6 alarm write in tick"); tk_sec = 0;
        step("R6"); check8(rd_data[6], 1'b1, "R6 old alarm compared");
        wr(5'h0E, 8'h4C, "R6");

        // R7 power-up cleared and never returns
        wr(5'h0E, 8'h80, "R7 clear");
        tk_sec = 1; tk_min = 1; tk_hour = 1; tk_day = 1;
        step("R7"); tk_sec = 0; tk_min = 0; tk_hour = 0; tk_day = 0;
        step("R7"); check8(rd_data, 8'h3C, "R7 power-up stays clear, R10 low bits");
        wr(5'h0E, 8'hFF, "R10"); step("R10");
        check8(rd_data, 8'h00, "R10 all clear");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule